// File: doc/BRIEF.md
# Entropy Pool with Pseudo-Random Filler

This block stands in for a true random-number source wherever no physical noise source exists. A 32-bit linear feedback shift register produces one pseudo-random bit per clock. Each bit is appended to a bounded pool of bits, and the pool's current fill level is visible on a port at all times. A consumer takes a 32-bit word by raising a read request for one cycle. The word holds the oldest bits in the pool. A read made while fewer than 32 bits are held counts as a fault and is not stalled. It returns zero, latches a sticky error that drives an interrupt line, and pulses an alert.

The only run-time control is an enable input. Lowering it empties the pool. The generator seed, feedback taps, pool capacity and word size are parameters.

A small state machine tracks the pool. In Idle the block is disabled and empty. In Fill it is enabled and below capacity. In Full it is enabled at capacity and generation pauses. The transitions are:
- enable-seen: Idle to Fill.
- reached-capacity: Fill to Full.
- word-taken: Full to Fill.
- disable: Fill or Full to Idle.

Top module: `rng_pool_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `avail_o` is 0, `err_irq_o` is 0 and `alert_o` is 0.
- R2: The generator state starts at the parameter SEED (default 0x00000001, must be nonzero). On each cycle that adds a bit, the new bit is the XOR of state bits 31, 21, 1 and 0. The state then shifts one place toward bit 31, with the new bit entering bit 0. In every other cycle the state holds, including while disabled.
- R3: A bit is added in a cycle when all three of these hold: `enable_i` is high in that cycle, the state is not Idle (enable was also high in the previous cycle), and `avail_o` is below POOL_BITS (default 128). `avail_o` then rises by 1 on the next cycle.
- R4: `avail_o` never exceeds POOL_BITS. While the pool is full, no bit is added and the generator holds.
- R5: A read succeeds when `rd_req_i` and `enable_i` are both high and `avail_o` is at least 32. In that same cycle, `rd_data_o` carries the 32 oldest pool bits, with the oldest at bit 0. On the next cycle, `avail_o` is the old count minus 32, plus 1 if a bit was also added. When no read succeeds, `rd_data_o` is 0.
- R6: Any other read is an underflow. This covers `avail_o` below 32 or `enable_i` low. An underflow returns 0 and removes no bits. On the next cycle `err_irq_o` is high, and `alert_o` is high for exactly that one cycle.
- R7: `err_irq_o` stays high until a cycle with `err_clr_i` high. That cycle clears it on the next cycle, unless the same cycle also holds an underflow, in which case the flag stays set.
- R8: A cycle with `enable_i` low makes `avail_o` 0 on the next cycle and discards all pool contents. The generator state is kept.
- R9: After the enable-seen transition out of Idle, the first bit is added one cycle after `enable_i` is first seen high. In Full the count equals POOL_BITS, and in Idle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run control; low flushes the pool |
| rd_req_i | input | 1 | Request to take one word this cycle |
| err_clr_i | input | 1 | Write-one-to-clear for the sticky error |
| rd_data_o | output | WORD_W (32) | Word returned by a successful read, else 0 |
| avail_o | output | $clog2(POOL_BITS+1) (8) | Number of bits held in the pool |
| err_irq_o | output | 1 | Sticky underflow error interrupt |
| alert_o | output | 1 | One-cycle pulse after an underflow |

## Verification
The bound checker runs on every cycle and covers these properties:
- the pool never goes above capacity;
- a count step of exactly one during idle filling;
- a drop of 31 or 32 after a successful read;
- emptying after a disable;
- zero data together with interrupt and alert after an underflow;
- alert pulses only after an underflow;
- the sticky and clear rules of the error flag;
- the pairing of Full and Idle with their counts.

Only the bench's reference model can show that the returned words carry the right generator bits in oldest-first order. The same holds for the generator holding its state across a full pool and across a disable. It also holds for exact boundary behaviour at 31 and 32 bits and for the one-cycle gap after re-enabling.

// File: rtl/rng_pool_pkg.sv
package rng_pool_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_FULL = 2'd2
    } pool_st_e;

endpackage

// File: rtl/rng_pool_lfsr.sv
module rng_pool_lfsr #(
    parameter int                 LFSR_W = 32,
    parameter logic [LFSR_W-1:0]  SEED   = 32'h0000_0001,
    parameter logic [LFSR_W-1:0]  TAPS   = 32'h8020_0003
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic bit_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic              fb;

    // feedback bit is the parity of the tapped positions
    always_comb begin
        fb = ^(lfsr_q & TAPS);
    end

    assign bit_o = fb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (step_i) begin
            lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
        end
    end

endmodule

// File: rtl/rng_pool_store.sv
module rng_pool_store #(
    parameter int POOL_BITS = 128,
    parameter int WORD_W    = 32,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              pop_i,
    input  logic              push_i,
    input  logic              bit_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int IDX_W = (POOL_BITS > 1) ? $clog2(POOL_BITS) : 1;
    localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);

    logic [POOL_BITS-1:0] pool_q;
    logic [POOL_BITS-1:0] pool_n;
    logic [CNT_W-1:0]     wr_pos;
    logic [IDX_W-1:0]     wr_idx;

    // new bit lands just above the bits that survive this cycle
    always_comb begin
        wr_pos = pop_i ? (count_i - WORD_C) : count_i;
        wr_idx = wr_pos[IDX_W-1:0];
    end

    always_comb begin
        pool_n = pop_i ? (pool_q >> WORD_W) : pool_q;
        if (push_i) begin
            pool_n[wr_idx] = bit_i;
        end
        if (flush_i) begin
            pool_n = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pool_q <= '0;
        end else begin
            pool_q <= pool_n;
        end
    end

    // oldest bits sit at the low end
    genvar gi;
    generate
        for (gi = 0; gi < WORD_W; gi++) begin : g_word
            assign word_o[gi] = pool_q[gi];
        end
    endgenerate

endmodule

// File: rtl/rng_pool_ctrl.sv
module rng_pool_ctrl
    import rng_pool_pkg::*;
#(
    parameter int POOL_BITS = 128,
    parameter int WORD_W    = 32,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             rd_req_i,
    input  logic             err_clr_i,
    output logic             gen_o,
    output logic             pop_o,
    output logic             under_o,
    output logic [CNT_W-1:0] count_o,
    output logic             err_o,
    output logic             alert_o,
    output pool_st_e         st_o
);

    localparam logic [CNT_W:0] POOL_L = (CNT_W+1)'(POOL_BITS);
    localparam logic [CNT_W:0] WORD_L = (CNT_W+1)'(WORD_W);

    pool_st_e         st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             err_q, err_n;
    logic             alert_q, alert_n;
    logic [CNT_W:0]   cnt_ext;

    // output process: decisions taken in the current state
    always_comb begin
        pop_o   = rd_req_i && enable_i && ({1'b0, cnt_q} >= WORD_L);
        under_o = rd_req_i && !pop_o;
        unique case (st_q)
            ST_IDLE: gen_o = 1'b0;
            ST_FILL: gen_o = enable_i;
            ST_FULL: gen_o = 1'b0;
            default: gen_o = 1'b0;
        endcase
    end

    // next-count and next-state
    always_comb begin
        cnt_ext = {1'b0, cnt_q};
        if (pop_o) begin
            cnt_ext = cnt_ext - WORD_L;
        end
        if (gen_o) begin
            cnt_ext = cnt_ext + 1'b1;
        end
        cnt_n = enable_i ? cnt_ext[CNT_W-1:0] : '0;

        unique case (st_q)
            ST_IDLE: st_n = enable_i ? ST_FILL : ST_IDLE;
            ST_FILL: begin
                if (!enable_i) begin
                    st_n = ST_IDLE;
                end else if (cnt_ext == POOL_L) begin
                    st_n = ST_FULL;
                end else begin
                    st_n = ST_FILL;
                end
            end
            ST_FULL: begin
                if (!enable_i) begin
                    st_n = ST_IDLE;
                end else if (pop_o) begin
                    st_n = ST_FILL;
                end else begin
                    st_n = ST_FULL;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (under_o) begin
            err_n = 1'b1;
        end else if (err_clr_i) begin
            err_n = 1'b0;
        end else begin
            err_n = err_q;
        end
        alert_n = under_o;
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            alert_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            err_q   <= err_n;
            alert_q <= alert_n;
        end
    end

    assign count_o = cnt_q;
    assign err_o   = err_q;
    assign alert_o = alert_q;
    assign st_o    = st_q;

endmodule

// File: rtl/rng_pool_top.sv
module rng_pool_top
    import rng_pool_pkg::*;
#(
    parameter int                POOL_BITS = 128,
    parameter int                WORD_W    = 32,
    parameter int                LFSR_W    = 32,
    parameter logic [LFSR_W-1:0] SEED      = 32'h0000_0001,
    parameter logic [LFSR_W-1:0] TAPS      = 32'h8020_0003,
    localparam int               CNT_W     = $clog2(POOL_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              rd_req_i,
    input  logic              err_clr_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  avail_o,
    output logic              err_irq_o,
    output logic              alert_o
);

    logic              gen_w;
    logic              pop_w;
    logic              under_w;
    logic              bit_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [WORD_W-1:0] word_w;
    pool_st_e          st_w;

    rng_pool_ctrl #(
        .POOL_BITS(POOL_BITS),
        .WORD_W   (WORD_W),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .rd_req_i (rd_req_i),
        .err_clr_i(err_clr_i),
        .gen_o    (gen_w),
        .pop_o    (pop_w),
        .under_o  (under_w),
        .count_o  (cnt_w),
        .err_o    (err_irq_o),
        .alert_o  (alert_o),
        .st_o     (st_w)
    );

    rng_pool_lfsr #(
        .LFSR_W(LFSR_W),
        .SEED  (SEED),
        .TAPS  (TAPS)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(gen_w),
        .bit_o (bit_w)
    );

    rng_pool_store #(
        .POOL_BITS(POOL_BITS),
        .WORD_W   (WORD_W),
        .CNT_W    (CNT_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush_i(!enable_i),
        .pop_i  (pop_w),
        .push_i (gen_w),
        .bit_i  (bit_w),
        .count_i(cnt_w),
        .word_o (word_w)
    );

    assign rd_data_o = pop_w ? word_w : '0;
    assign avail_o   = cnt_w;

endmodule

// File: rtl/rng_pool_chk.sv
module rng_pool_chk
    import rng_pool_pkg::*;
#(
    parameter int POOL_BITS = 128,
    parameter int WORD_W    = 32,
    parameter int CNT_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              rd_req_i,
    input logic              err_clr_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic [CNT_W-1:0]  avail_o,
    input logic              err_irq_o,
    input logic              alert_o,
    input pool_st_e          st
);

    logic uf;
    assign uf = rd_req_i && !(enable_i && (int'(avail_o) >= WORD_W));

    a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(avail_o) <= POOL_BITS);

    a_r3_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !rd_req_i && st != ST_IDLE && int'(avail_o) < POOL_BITS)
        |=> int'(avail_o) == int'($past(avail_o)) + 1);

    a_r5_read_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && enable_i && int'(avail_o) >= WORD_W)
        |=> (int'(avail_o) == int'($past(avail_o)) - WORD_W) ||
            (int'(avail_o) == int'($past(avail_o)) - WORD_W + 1));

    a_r6_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        uf |-> rd_data_o == '0);

    a_r6_flag_alert: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (err_irq_o && alert_o));

    a_r6_alert_src: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |-> $past(uf));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq_o && !err_clr_i) |=> err_irq_o);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !uf) |=> !err_irq_o);

    a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> avail_o == '0);

    a_r9_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FULL) |-> int'(avail_o) == POOL_BITS);

    a_r9_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> avail_o == '0);

endmodule

bind rng_pool_top rng_pool_chk #(
    .POOL_BITS(POOL_BITS),
    .WORD_W   (WORD_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .rd_req_i (rd_req_i),
    .err_clr_i(err_clr_i),
    .rd_data_o(rd_data_o),
    .avail_o  (avail_o),
    .err_irq_o(err_irq_o),
    .alert_o  (alert_o),
    .st       (st_w)
);

// File: tb/sim_rng_pool_top.sv
module sim_rng_pool_top;

    localparam int POOL = 128;
    localparam int WORD = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        rd_req_i = 1'b0;
    logic        err_clr_i = 1'b0;
    logic [31:0] rd_data_o;
    logic [7:0]  avail_o;
    logic        err_irq_o;
    logic        alert_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    bit          m_q[$];
    logic [31:0] m_lfsr = 32'h0000_0001;
    bit          m_act = 1'b0;
    bit          m_err = 1'b0;
    bit          m_alert = 1'b0;

    always #2 clk = ~clk;

    rng_pool_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .rd_req_i (rd_req_i),
        .err_clr_i(err_clr_i),
        .rd_data_o(rd_data_o),
        .avail_o  (avail_o),
        .err_irq_o(err_irq_o),
        .alert_o  (alert_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, compare against the model, advance the model
    task automatic step(input bit en, input bit rd, input bit clr, input string tag);
        bit          ok;
        bit          uf;
        bit          gen;
        bit          fb;
        logic [31:0] exp_data;
        @(negedge clk);
        enable_i  = en;
        rd_req_i  = rd;
        err_clr_i = clr;
        #1;
        chk("R3 count", 32'(avail_o), 32'(m_q.size()));
        chk("R7 err flag", 32'(err_irq_o), 32'(m_err));
        chk("R6 alert", 32'(alert_o), 32'(m_alert));
        ok = rd && en && (m_q.size() >= WORD);
        uf = rd && !ok;
        exp_data = '0;
        if (ok) begin
            for (int i = 0; i < WORD; i++) exp_data[i] = m_q[i];
        end
        if (rd) chk(uf ? "R6 data" : tag, rd_data_o, exp_data);
        gen = en && m_act && (m_q.size() < POOL);
        if (!en) begin
            m_q.delete();
            m_act = 1'b0;
        end else begin
            if (ok) begin
                for (int i = 0; i < WORD; i++) void'(m_q.pop_front());
            end
            if (gen) begin
                fb = m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0];
                m_lfsr = {m_lfsr[30:0], fb};
                m_q.push_back(fb);
            end
            m_act = 1'b1;
        end
        if (uf) m_err = 1'b1;
        else if (clr) m_err = 1'b0;
        m_alert = uf;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 count", 32'(avail_o), 0);
        chk("R1 err", 32'(err_irq_o), 0);
        chk("R1 alert", 32'(alert_o), 0);
        rst_n = 1'b1;

        // fill to capacity and hold there
        for (int i = 0; i < 150; i++) step(1, 0, 0, i < 129 ? "R3" : "R4");
        // back-to-back reads from full down to underflow
        for (int i = 0; i < 5; i++) step(1, 1, 0, "R5 word");
        step(1, 0, 0, "R6");
        step(1, 0, 0, "R7 hold");
        step(1, 0, 1, "R7 clear");
        step(1, 0, 0, "R7 cleared");
        // boundary: walk up to 31 bits, read (fails), then read at 32
        while (m_q.size() < 31) step(1, 0, 0, "R3");
        step(1, 1, 0, "R6 at 31");
        step(1, 1, 0, "R5 at 32");
        // clear and underflow in the same cycle: set wins
        step(1, 1, 1, "R7 set wins");
        step(1, 0, 0, "R7 set wins");
        step(1, 0, 1, "R7");
        // disable mid-fill, read while disabled, re-enable
        for (int i = 0; i < 40; i++) step(1, 0, 0, "R3");
        step(0, 0, 0, "R8");
        step(0, 1, 0, "R8 disabled read");
        step(0, 0, 1, "R8");
        step(1, 0, 0, "R9 enable seen");
        step(1, 0, 0, "R9 first bit");
        for (int i = 0; i < 60; i++) step(1, 0, 0, "R2");
        step(1, 1, 0, "R2 word after re-enable");
        // mixed traffic
        for (int i = 0; i < 500; i++) begin
            step(!((i % 97) >= 90 && (i % 97) <= 92), (i % 7) == 0, (i % 11) == 0, "R5 mixed");
        end
        for (int i = 0; i < 130; i++) step(1, 0, 0, "R4");
        for (int i = 0; i < 4; i++) step(1, 1, 0, "R5 drain");
        step(1, 0, 0, "R5");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule